// File: doc/BRIEF.md
# Clock Source Switchover Sequencer

This block keeps a processor clock running while the PLL that feeds it is retuned. It drives two mux select lines of the clock divider path. The first is the output select: 0 routes the crystal straight to the processor clock and 1 routes the divider output. The second is the divider source select: 0 feeds the divider from the crystal and 1 feeds it from the PLL.

A park request comes before the PLL is reprogrammed. The sequencer moves the output onto the crystal, waits a settle interval and then points the divider input at the PLL. A restore request comes once the PLL has locked. The sequencer returns the output to the divider path and waits the settle interval again. The crystal is only a stand-in while the PLL frequency moves.

The settle interval is a parameter counted in reference-clock cycles. The default is 2400 cycles, which is 100 µs at 24 MHz. A busy flag covers each wait. A one-cycle done pulse per phase marks its end. Requests that arrive while a phase is running are held and served in order.

Top module: `clk_park_seq`

## Requirements
- R1: After reset, out_sel_o and div_sel_o are both 0 (crystal), busy_o is 0 and neither done pulse is high.
- R2: When a park request is accepted from idle, out_sel_o goes to 0 on that same clock edge and div_sel_o keeps its value during the wait.
- R3: div_sel_o goes to 1 exactly SETTLE_CYCLES clock edges after the edge that cleared out_sel_o for a park, and at no other time.
- R4: When a restore request is accepted from idle, out_sel_o goes to 1 on that same clock edge and div_sel_o is not changed by the restore phase.
- R5: busy_o is high for exactly SETTLE_CYCLES consecutive cycles per accepted phase, starting the cycle after acceptance.
- R6: park_done_o or restore_done_o is high for exactly one cycle, in the first cycle after busy_o falls for that phase.
- R7: A request that arrives while a phase runs is held and accepted in the cycle its done pulse is high. When both kinds are pending, or arrive in the same idle cycle, the park phase runs first.
- R8: A restore request with no earlier park is accepted and only sets out_sel_o to 1, leaving div_sel_o at 0.
- R9: Repeated requests of one kind arriving while the held request of that kind is still pending produce a single phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| park_req_i | input | 1 | Request to park on the crystal before a PLL change (one-cycle strobe) |
| restore_req_i | input | 1 | Request to return to the divider path after a PLL change (one-cycle strobe) |
| out_sel_o | output | 1 | Output mux select: 0 crystal, 1 divider output |
| div_sel_o | output | 1 | Divider input select: 0 crystal, 1 PLL |
| busy_o | output | 1 | High during each settle wait |
| park_done_o | output | 1 | One-cycle pulse when a park phase ends |
| restore_done_o | output | 1 | One-cycle pulse when a restore phase ends |

## Verification
The bench builds the sequencer with SETTLE_CYCLES set to 5 instead of 2400. With that value a full park and restore pair takes about a dozen cycles. This lets thousands of random request patterns run, including requests landing on the first, middle and last wait cycle and on the done cycle itself. The short interval also keeps the exact busy length and the div_sel_o timing easy to count directly in the directed cases.

// File: rtl/clk_park_pkg.sv
package clk_park_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_PARK    = 2'd1,
        PH_RESTORE = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   out_sel;
        logic   div_sel;
        logic   park_done;
        logic   restore_done;
    } seq_state_t;

    localparam int unsigned REQ_PARK    = 0;
    localparam int unsigned REQ_RESTORE = 1;
    localparam int unsigned NUM_REQ     = 2;

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int unsigned CYCLES = 2400,
    parameter int unsigned CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic last_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CNT_W'(1));

    // R5: the count never exceeds the programmed interval
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CYCLES));

    // R5: a running count steps down by one each cycle unless reloaded
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > CNT_W'(1) && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/req_hold.sv
module req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic clr_i,
    output logic want_o
);

    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q | req_i;
        if (clr_i) pend_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign want_o = pend_q | req_i;

    // R7: a held request stays held until it is consumed
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_i) |=> pend_q);

    // R9: consuming a request leaves nothing pending on the next cycle
    a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !pend_q);

endmodule

// File: rtl/clk_park_seq.sv
module clk_park_seq
    import clk_park_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 2400,
    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic park_req_i,
    input  logic restore_req_i,
    output logic out_sel_o,
    output logic div_sel_o,
    output logic busy_o,
    output logic park_done_o,
    output logic restore_done_o
);

    seq_state_t st_d, st_q;
    logic [NUM_REQ-1:0] req_raw;
    logic [NUM_REQ-1:0] want;
    logic [NUM_REQ-1:0] clr;
    logic               tmr_load;
    logic               tmr_last;

    assign req_raw[REQ_PARK]    = park_req_i;
    assign req_raw[REQ_RESTORE] = restore_req_i;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        req_hold u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (req_raw[g]),
            .clr_i  (clr[g]),
            .want_o (want[g])
        );
    end

    settle_timer #(
        .CYCLES (SETTLE_CYCLES),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .last_o (tmr_last)
    );

    always_comb begin
        st_d              = st_q;
        st_d.park_done    = 1'b0;
        st_d.restore_done = 1'b0;
        tmr_load          = 1'b0;
        clr               = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (want[REQ_PARK]) begin
                    st_d.phase    = PH_PARK;
                    st_d.out_sel  = 1'b0;
                    tmr_load      = 1'b1;
                    clr[REQ_PARK] = 1'b1;
                end else if (want[REQ_RESTORE]) begin
                    st_d.phase       = PH_RESTORE;
                    st_d.out_sel     = 1'b1;
                    tmr_load         = 1'b1;
                    clr[REQ_RESTORE] = 1'b1;
                end
            end
            PH_PARK: begin
                if (tmr_last) begin
                    st_d.phase     = PH_IDLE;
                    st_d.div_sel   = 1'b1;
                    st_d.park_done = 1'b1;
                end
            end
            PH_RESTORE: begin
                if (tmr_last) begin
                    st_d.phase        = PH_IDLE;
                    st_d.restore_done = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, out_sel: 1'b0, div_sel: 1'b0,
                      park_done: 1'b0, restore_done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_sel_o      = st_q.out_sel;
    assign div_sel_o      = st_q.div_sel;
    assign busy_o         = (st_q.phase != PH_IDLE);
    assign park_done_o    = st_q.park_done;
    assign restore_done_o = st_q.restore_done;

    // R2: the output leaves the divider path only as a wait begins
    a_r2_park_enter: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_sel_o) |-> busy_o);

    // R2: the divider input stays put while a park wait runs
    a_r2_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !out_sel_o && $past(busy_o)) |-> $stable(div_sel_o));

    // R3: the divider input moves to the PLL only when a park phase ends
    a_r3_div_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_sel_o) |-> park_done_o);

    // R4: restoring the output starts a wait
    a_r4_restore_enter: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_sel_o) |-> busy_o);

    // R6: done pulses last one cycle and mark the end of a wait
    a_r6_park_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        park_done_o |=> !park_done_o);
    a_r6_restore_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        restore_done_o |=> !restore_done_o);
    a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (park_done_o || restore_done_o) |-> $fell(busy_o));
    a_r6_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({park_done_o, restore_done_o}));

    // R5: a wait does not end before the timer reaches its last count
    a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tmr_last) |=> busy_o);

endmodule

// File: tb/clk_park_seq_tb_top.sv
module clk_park_seq_tb_top;

    localparam int unsigned SETTLE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic park_req = 1'b0;
    logic restore_req = 1'b0;
    logic out_sel, div_sel, busy, park_done, restore_done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    clk_park_seq #(.SETTLE_CYCLES(SETTLE)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .park_req_i     (park_req),
        .restore_req_i  (restore_req),
        .out_sel_o      (out_sel),
        .div_sel_o      (div_sel),
        .busy_o         (busy),
        .park_done_o    (park_done),
        .restore_done_o (restore_done)
    );

    // Reference model written from the requirements: phase 0 idle, 1 park, 2 restore.
    int   m_phase = 0;
    int   m_elapsed = 0;
    logic m_pp = 1'b0, m_pr = 1'b0;
    logic m_out = 1'b0, m_div = 1'b0, m_pd = 1'b0, m_rd = 1'b0;

    function automatic logic next_pending(input logic held, input logic strobe,
                                          input logic taken);
        return taken ? 1'b0 : (held | strobe);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase <= 0; m_elapsed <= 0; m_pp <= 0; m_pr <= 0;
            m_out <= 0; m_div <= 0; m_pd <= 0; m_rd <= 0;
        end else begin
            logic wp, wr;
            wp = m_pp | park_req;
            wr = m_pr | restore_req;
            m_pd <= 1'b0;
            m_rd <= 1'b0;
            if (m_phase == 0) begin
                m_pp <= next_pending(m_pp, park_req, wp);
                m_pr <= next_pending(m_pr, restore_req, !wp && wr);
                if (wp) begin
                    m_phase <= 1; m_out <= 1'b0; m_elapsed <= 0;
                end else if (wr) begin
                    m_phase <= 2; m_out <= 1'b1; m_elapsed <= 0;
                end
            end else begin
                m_pp <= wp;
                m_pr <= wr;
                m_elapsed <= m_elapsed + 1;
                if (m_elapsed == SETTLE - 1) begin
                    if (m_phase == 1) begin m_div <= 1'b1; m_pd <= 1'b1; end
                    else m_rd <= 1'b1;
                    m_phase <= 0;
                end
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare_model();
        check("R2/R4 out_sel", out_sel, m_out);
        check("R3 div_sel", div_sel, m_div);
        check("R5 busy", busy, logic'(m_phase != 0));
        check("R6 park_done", park_done, m_pd);
        check("R6 restore_done", restore_done, m_rd);
    endtask

    // One clock: the inputs already set are taken at the rising edge, outputs sampled at the falling edge.
    task automatic step(input logic p, input logic r);
        park_req = p;
        restore_req = r;
        @(posedge clk);
        @(negedge clk);
        cycles++;
        park_req = 1'b0;
        restore_req = 1'b0;
        compare_model();
    endtask

    task automatic idle_wait(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int busy_len;
        int div_at;
        int seed;
        seed = $urandom(32'h5EED_C10C);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_sel", out_sel, 1'b0);
        check("R1 div_sel", div_sel, 1'b0);
        check("R1 busy", busy, 1'b0);
        check("R1 done", park_done | restore_done, 1'b0);
        rst_n = 1'b1;
        idle_wait(2);

        // R8: restore with no earlier park
        step(1'b0, 1'b1);
        check("R8 out_sel", out_sel, 1'b1);
        idle_wait(SETTLE + 1);
        check("R8 div_sel", div_sel, 1'b0);

        // R2 R3 R5 R6: park phase timing
        step(1'b1, 1'b0);
        check("R2 out_sel cleared", out_sel, 1'b0);
        busy_len = 0;
        div_at = -1;
        for (int i = 1; i <= SETTLE + 2; i++) begin
            if (busy) busy_len++;
            if (div_sel && div_at < 0) div_at = i - 1;
            if (park_done) check("R6 done after busy", busy, 1'b0);
            step(1'b0, 1'b0);
        end
        check("R5 busy length", logic'(busy_len == SETTLE), 1'b1);
        check("R3 div timing", logic'(div_at == SETTLE), 1'b1);

        // R7: restore arriving mid-park waits for the park to finish
        step(1'b1, 1'b0);
        idle_wait(2);
        step(1'b0, 1'b1);
        idle_wait(SETTLE - 3);
        check("R7 park done", park_done, 1'b1);
        check("R7 still parked", out_sel, 1'b0);
        step(1'b0, 1'b0);
        check("R7 restore follows", out_sel & busy, 1'b1);
        idle_wait(SETTLE + 2);

        // R7: simultaneous requests, park first
        step(1'b1, 1'b1);
        check("R7 park first", out_sel, 1'b0);
        idle_wait(2 * SETTLE + 3);
        check("R7 restored", out_sel, 1'b1);

        // R9: repeated restore strobes during a park give one restore phase
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        idle_wait(2 * SETTLE + 1);
        check("R9 single restore", busy, 1'b0);
        idle_wait(3);
        check("R9 stays idle", busy, 1'b0);

        // Random request patterns against the model
        for (int i = 0; i < 4000; i++) begin
            step(logic'($urandom_range(0, 15) == 0), logic'($urandom_range(0, 15) == 0));
        end
        idle_wait(3 * SETTLE);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule